// File: doc/BRIEF.md
# Execute Packet Dispatcher

The block sits between instruction fetch and the functional-unit lanes of a wide-issue core. It takes one fetch packet at a time, holds it, and splits it into variable-length execute packets. Each instruction slot carries a chain flag in its least significant bit. A set flag ties the next slot to the same execute packet. A clear flag closes the packet. The last slot of a fetch packet always closes the packet, whatever its flag says.

Each cycle the downstream side accepts with a ready signal, and the block presents one execute packet across up to eight lanes. Lane 0 carries the first slot not yet issued, and the following lanes carry the slots after it in order. A new fetch packet is requested only when every execute packet of the held one has gone out. A flush drops whatever is still held and asks for a fresh fetch packet on the next cycle.

Top module: `pkt_dispatch`

## Requirements
- R1: After reset, fetch_req is 1 and every lane_valid bit is 0.
- R2: Slot k of fetch_data is bits [32k+31:32k]. An instruction whose bit 0 is 1 is followed in the same execute packet by the next slot. An instruction whose bit 0 is 0 is the last of its execute packet.
- R3: Slot 7 always ends an execute packet, even when its bit 0 is 1.
- R4: While a packet is held and issue_ready is 1, exactly one execute packet issues per cycle. Lane j carries slot s+j, where s is the first unissued slot. The next cycle shows the following execute packet.
- R5: Lanes beyond the current execute packet drive lane_valid 0 and a lane_instr of zero. The valid lanes always form a contiguous run starting at lane 0.
- R6: fetch_req is 1 exactly when no packet is held. A fetch packet is captured on a cycle with fetch_req and fetch_valid both 1. fetch_req goes back to 1 in the cycle after the last execute packet issues.
- R7: While issue_ready is 0, lane_valid and lane_instr hold their values, and fetch_req stays 0.
- R8: A flush drops the held packet. The next cycle shows lane_valid 0 and fetch_req 1. fetch data offered in the same cycle as a flush is discarded.
- R9: fetch_valid is ignored while fetch_req is 0. The held packet and the lane outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard the held fetch packet |
| fetch_req | output | 1 | Request for the next fetch packet |
| fetch_valid | input | 1 | fetch_data carries a fetch packet |
| fetch_data | input | 256 | Eight 32-bit slots, slot 0 in the low bits |
| issue_ready | input | 1 | Downstream accepts the presented execute packet |
| lane_valid | output | 8 | Per-lane valid, contiguous from lane 0 |
| lane_instr | output | 256 | Per-lane instruction, lane 0 in the low bits |

## Verification
A corrupted start pointer shows up in the same cycle it is wrong: lane 0 carries the wrong slot, or a run has the wrong length compared with the chain flags. A wrong held or empty flag shows at once as fetch_req overlapping valid lanes, or as a packet that reissues or vanishes. Boundary errors, such as the slot 7 flag being honoured or a packet crossing into the next fetch packet, show within one fetch packet as an extra lane or a missing fetch request.

// File: rtl/pkt_dispatch_pkg.sv
// Shared constants for the execute packet dispatcher.
// Assumes the chain flag sits in bit 0 of every instruction word.
package pkt_dispatch_pkg;
    localparam int unsigned CHAIN_BIT = 0;
    typedef enum logic {BUF_EMPTY = 1'b0, BUF_HELD = 1'b1} buf_state_t;
endpackage

// File: rtl/pd_boundary.sv
// Finds the extent of the execute packet that starts at a given slot.
// Walks the chain flags from the start slot, stopping at the first clear
// flag or at the last slot. Purely combinational.
module pd_boundary #(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned PW = $clog2(SLOTS),
    localparam int unsigned CW = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0] chain,
    input  logic [PW-1:0]    start,
    output logic [CW-1:0]    count,
    output logic             ends_fetch
);
    logic stop;

    // Purpose: count slots from start up to and including the packet end.
    always_comb begin
        stop  = 1'b0;
        count = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (i >= int'(start) && !stop) begin
                count = count + CW'(1);
                if (!chain[i] || i == SLOTS - 1) stop = 1'b1;
            end
        end
    end

    // Purpose: flag that this execute packet reaches the final slot.
    always_comb ends_fetch = (int'(start) + int'(count) == SLOTS);
endmodule

// File: rtl/pd_buffer.sv
// Holds one fetch packet and the index of its first unissued slot.
// Assumes flush outranks everything and that capture only happens while
// empty, so capture and issue never coincide.
module pd_buffer
    import pkt_dispatch_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned IW = 32,
    localparam int unsigned PW = $clog2(SLOTS),
    localparam int unsigned FW = SLOTS * IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          fetch_valid,
    input  logic [FW-1:0] fetch_data,
    input  logic          advance,
    input  logic          advance_last,
    input  logic [PW-1:0] next_start,
    output logic          held,
    output logic [PW-1:0] start,
    output logic [FW-1:0] slots
);
    buf_state_t state;
    logic       capture;

    // Purpose: accept a fetch packet only when empty and not flushing.
    always_comb capture = (state == BUF_EMPTY) && fetch_valid && !flush;

    // Purpose: occupancy state and start slot update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BUF_EMPTY;
            start <= '0;
        end else if (flush) begin
            state <= BUF_EMPTY;
            start <= '0;
        end else if (capture) begin
            state <= BUF_HELD;
            start <= '0;
        end else if (advance) begin
            if (advance_last) begin
                state <= BUF_EMPTY;
                start <= '0;
            end else begin
                start <= next_start;
            end
        end
    end

    // Purpose: packet storage, loaded on capture only.
    always_ff @(posedge clk) begin
        if (!rst_n)       slots <= '0;
        else if (capture) slots <= fetch_data;
    end

    always_comb held = (state == BUF_HELD);

    a_r6_capture_fills: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (held && start == '0));
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !held);
    a_r9_no_reload_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !flush) |=> $stable(slots));
endmodule

// File: rtl/pd_lane_mux.sv
// Aligns the current execute packet onto the lanes: lane j takes slot
// start+j. Lanes past the packet drive valid low and zero data.
module pd_lane_mux #(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned IW = 32,
    localparam int unsigned PW = $clog2(SLOTS),
    localparam int unsigned CW = $clog2(SLOTS + 1),
    localparam int unsigned FW = SLOTS * IW
) (
    input  logic             held,
    input  logic [PW-1:0]    start,
    input  logic [CW-1:0]    count,
    input  logic [FW-1:0]    slots,
    output logic [SLOTS-1:0] lane_valid,
    output logic [FW-1:0]    lane_instr
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_lane
        logic [PW-1:0] sel;
        // Purpose: pick the slot for this lane and gate it by packet length.
        always_comb begin
            sel           = start + PW'(g);
            lane_valid[g] = held && (g < int'(count));
            lane_instr[g*IW +: IW] = lane_valid[g] ? slots[sel*IW +: IW] : '0;
        end
    end
endmodule

// File: rtl/pkt_dispatch.sv
// Execute packet dispatcher: splits held fetch packets into chained
// execute packets and issues one per ready cycle across the lanes.
// Assumes a downstream that takes the whole packet when issue_ready is 1.
module pkt_dispatch
    import pkt_dispatch_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned IW = 32,
    localparam int unsigned PW = $clog2(SLOTS),
    localparam int unsigned CW = $clog2(SLOTS + 1),
    localparam int unsigned FW = SLOTS * IW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    output logic             fetch_req,
    input  logic             fetch_valid,
    input  logic [FW-1:0]    fetch_data,
    input  logic             issue_ready,
    output logic [SLOTS-1:0] lane_valid,
    output logic [FW-1:0]    lane_instr
);
    logic             held;
    logic [PW-1:0]    start;
    logic [FW-1:0]    slots;
    logic [SLOTS-1:0] chain;
    logic [CW-1:0]    count;
    logic             ends_fetch;
    logic             advance;

    // Purpose: gather the chain flag of every held slot.
    always_comb
        for (int i = 0; i < SLOTS; i++) chain[i] = slots[i*IW + CHAIN_BIT];

    // Purpose: issue handshake and fetch request.
    always_comb begin
        advance   = held && issue_ready;
        fetch_req = !held;
    end

    pd_buffer #(.SLOTS(SLOTS), .IW(IW)) u_buf (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .advance(advance), .advance_last(ends_fetch),
        .next_start(start + PW'(count)),
        .held(held), .start(start), .slots(slots)
    );

    pd_boundary #(.SLOTS(SLOTS)) u_bound (
        .chain(chain), .start(start), .count(count), .ends_fetch(ends_fetch)
    );

    pd_lane_mux #(.SLOTS(SLOTS), .IW(IW)) u_mux (
        .held(held), .start(start), .count(count), .slots(slots),
        .lane_valid(lane_valid), .lane_instr(lane_instr)
    );

    a_r1_reset_state: assert property (@(posedge clk)
        $past(!rst_n) |-> (fetch_req && lane_valid == '0));
    a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({1'b0, lane_valid} + (SLOTS+1)'(1)));
    a_r6_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req && lane_valid[0]));
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid[0] && !issue_ready && !flush) |=>
            ($stable(lane_valid) && $stable(lane_instr)));
    a_r8_flush_request: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fetch_req && lane_valid == '0));
    for (genvar g = 0; g < SLOTS - 1; g++) begin : g_chk
        a_r2_chained_lane: assert property (@(posedge clk) disable iff (!rst_n)
            lane_valid[g+1] |-> lane_instr[g*IW + CHAIN_BIT]);
    end
endmodule

// File: tb/sim_pkt_dispatch.sv
module sim_pkt_dispatch;
    localparam int SLOTS = 8;
    localparam int IW = 32;
    localparam int FW = SLOTS * IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic fetch_req;
    logic fetch_valid = 1'b0;
    logic [FW-1:0] fetch_data = '0;
    logic issue_ready = 1'b1;
    logic [SLOTS-1:0] lane_valid;
    logic [FW-1:0] lane_instr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [FW-1:0] pkt;

    always #4 clk = ~clk;

    pkt_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_req(fetch_req),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .issue_ready(issue_ready), .lane_valid(lane_valid), .lane_instr(lane_instr)
    );

    task automatic chk(input bit ok, input string req, input logic [FW-1:0] act,
                       input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] make_pkt(input logic [7:0] tag, input logic [7:0] chains);
        logic [FW-1:0] p;
        for (int s = 0; s < SLOTS; s++)
            p[s*IW +: IW] = {tag, 8'(s), 15'h2a5c, chains[s]};
        return p;
    endfunction

    // Offer a packet while fetch_req is high; ends one negedge later.
    task automatic load(input logic [FW-1:0] d);
        chk(fetch_req == 1'b1, "R6 request before load", FW'(fetch_req), FW'(1));
        fetch_valid = 1'b1;
        fetch_data = d;
        pkt = d;
        @(negedge clk);
        fetch_valid = 1'b0;
        chk(fetch_req == 1'b0, "R6 request drops when held", FW'(fetch_req), FW'(0));
    endtask

    // Compare lanes with slots first..first+n-1 of the held packet.
    task automatic see_group(input int first, input int n, input string req);
        logic [FW-1:0] exp;
        logic [SLOTS-1:0] vexp;
        exp = '0;
        vexp = SLOTS'((9'd1 << n) - 9'd1);
        for (int j = 0; j < n; j++) exp[j*IW +: IW] = pkt[(first+j)*IW +: IW];
        chk(lane_valid == vexp, {req, " R5 lane_valid"}, FW'(lane_valid), FW'(vexp));
        chk(lane_instr == exp, {req, " R4 lane_instr"}, lane_instr, exp);
    endtask

    // Issue a list of groups, then expect the next fetch request (R4, R6).
    task automatic run_groups(input int ng, input logic [31:0] firsts,
                              input logic [31:0] counts, input string req);
        for (int g = 0; g < ng; g++) begin
            see_group(int'(firsts[g*4 +: 4]), int'(counts[g*4 +: 4]), req);
            @(negedge clk);
        end
        chk(fetch_req == 1'b1, {req, " R6 refetch after drain"}, FW'(fetch_req), FW'(1));
        chk(lane_valid == '0, {req, " R5 empty lanes"}, FW'(lane_valid), FW'(0));
    endtask

    task automatic t_reset;
        chk(fetch_req == 1'b1, "R1 fetch_req", FW'(fetch_req), FW'(1));
        chk(lane_valid == '0, "R1 lane_valid", FW'(lane_valid), FW'(0));
    endtask

    // R2 R3: every flag set, slot 7 flag set but ignored -> one group of 8.
    task automatic t_all_chained;
        load(make_pkt(8'hA1, 8'hFF));
        run_groups(1, 32'h0, 32'h8, "R3 all chained");
    endtask

    // R2: no flag set -> eight single-slot groups.
    task automatic t_singles;
        load(make_pkt(8'hB2, 8'h00));
        run_groups(8, 32'h7654_3210, 32'h1111_1111, "R2 singles");
    endtask

    // R2 R3: flags 1,0,1,1,0,0,1,0 (slot 0 first) -> {0,1},{2..4},{5},{6,7}.
    task automatic t_mixed;
        load(make_pkt(8'hC3, 8'b0100_1101));
        run_groups(4, 32'h6520, 32'h2132, "R2 mixed");
    endtask

    // R3: flags 1,1,1,0,1,1,1,1 -> {0..3},{4..7}.
    task automatic t_tail_flag;
        load(make_pkt(8'hD4, 8'b1111_0111));
        run_groups(2, 32'h40, 32'h44, "R3 tail flag");
    endtask

    // R7 R9: stall mid-packet while a stray fetch is offered.
    task automatic t_stall;
        load(make_pkt(8'hE5, 8'b0100_1101));
        see_group(0, 2, "R4 pre-stall");
        @(negedge clk);
        issue_ready = 1'b0;
        fetch_valid = 1'b1;
        fetch_data = make_pkt(8'h5E, 8'h00);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            see_group(2, 3, "R7 stalled");
            chk(fetch_req == 1'b0, "R7 no request in stall", FW'(fetch_req), FW'(0));
        end
        fetch_valid = 1'b0;
        issue_ready = 1'b1;
        see_group(2, 3, "R9 stray fetch ignored");
        @(negedge clk);
        run_groups(2, 32'h65, 32'h21, "R7 resume");
    endtask

    // R8: flush mid-packet, then flush racing a fetch.
    task automatic t_flush;
        load(make_pkt(8'hF6, 8'h00));
        see_group(0, 1, "R8 pre-flush");
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(lane_valid == '0, "R8 lanes cleared", FW'(lane_valid), FW'(0));
        chk(fetch_req == 1'b1, "R8 request after flush", FW'(fetch_req), FW'(1));
        flush = 1'b1;
        fetch_valid = 1'b1;
        fetch_data = make_pkt(8'h77, 8'hFF);
        @(negedge clk);
        flush = 1'b0;
        fetch_valid = 1'b0;
        chk(lane_valid == '0, "R8 fetch during flush dropped", FW'(lane_valid), FW'(0));
        chk(fetch_req == 1'b1, "R8 still requesting", FW'(fetch_req), FW'(1));
        load(make_pkt(8'h88, 8'b0000_0011));
        run_groups(6, 32'h76_5430, 32'h11_1113, "R8 after flush");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_all_chained;
        t_singles;
        t_mixed;
        t_tail_flag;
        t_stall;
        t_flush;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule